// File: doc/BRIEF.md
# SDIO Multi-Function Transfer Controller

This block sits behind an SDIO command and data front end. The front end hands it a decoded transfer command: the target function number, a block size or byte count, a block count, the direction and whether block mode is used. The controller checks the request against the largest size allowed for that function. A request that fits opens a transfer. One that does not is refused with a single-cycle range error, and no transfer starts. During a transfer the front end reports each finished block. The controller counts down the blocks still owed and pulses a completion flag when the last one is in.

Three functions are served. Function 0 is the standard control function and allows at most 32 bytes. Function 1 reaches the on-chip backplane and allows at most 64 bytes. Function 2 is the packet DMA path and allows at most 512 bytes.

The controller also raises the card interrupt in two forms from per-function requests, per-function enables and a master enable. The out-of-band pin is combinational, so it stays valid even while the bus clock is stopped. The in-band form pulls data line 1 low only in 4-bit bus mode and only while the data lines are not busy. A clock-enable input stands for the stopped bus clock: while it is low, all registered state is held.

Top module: `sdio_xfer_ctrl`

## Requirements
- R1: After a synchronous active-low reset, xfer_active, xfer_fn, xfer_write, xfer_size, blocks_left, xfer_done and err_range are all zero.
- R2: A command (cmd_valid=1 while idle, clk_en=1) with cmd_fn 0, 1 or 2 and cmd_size from 1 up to 32, 64 or 512 respectively is accepted. On the next cycle xfer_active=1, and xfer_fn, xfer_write and xfer_size hold the command's values.
- R3: A command is refused when cmd_size exceeds its function's maximum, when cmd_size is 0, when cmd_fn is 3, or when block mode (cmd_block=1) has cmd_count 0. Refusal raises err_range for exactly one cycle, and xfer_active stays 0.
- R4: An accepted block-mode command loads blocks_left with cmd_count. An accepted byte-mode command (cmd_block=0) loads blocks_left with 1.
- R5: While active, each blk_done decrements blocks_left. The one that takes it to 0 clears xfer_active and raises xfer_done for exactly one cycle.
- R6: cmd_valid while a transfer is active has no effect, and blk_done while idle has no effect.
- R7: While clk_en=0, every registered output holds its value and both cmd_valid and blk_done are ignored. Reset still takes effect.
- R8: oob_irq equals irq_master_en AND the OR over functions of (irq_req & irq_en). It is unaffected by clk_en, dat_busy and bus width.
- R9: dat1_irq_n is 0 only when bus_4bit=1, dat_busy=0 and the oob condition of R8 holds. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Low while the bus clock is stopped; state is held |
| cmd_valid | input | 1 | Decoded command present for one cycle |
| cmd_fn | input | 2 | Target function number |
| cmd_write | input | 1 | 1 = host to card |
| cmd_block | input | 1 | 1 = block mode, 0 = byte mode |
| cmd_size | input | 10 | Block size or byte count |
| cmd_count | input | 9 | Number of blocks in block mode |
| blk_done | input | 1 | Front end finished one block |
| dat_busy | input | 1 | Data lines are being driven |
| bus_4bit | input | 1 | 1 = 4-bit data bus, 0 = 1-bit |
| irq_req | input | 3 | Per-function interrupt request |
| irq_en | input | 3 | Per-function interrupt enable |
| irq_master_en | input | 1 | Master interrupt enable |
| xfer_active | output | 1 | Transfer in progress |
| xfer_fn | output | 2 | Function of the current transfer |
| xfer_write | output | 1 | Direction of the current transfer |
| xfer_size | output | 10 | Size of the current transfer |
| blocks_left | output | 9 | Blocks still owed |
| xfer_done | output | 1 | One-cycle completion flag |
| err_range | output | 1 | One-cycle refusal flag |
| oob_irq | output | 1 | Out-of-band interrupt, always valid |
| dat1_irq_n | output | 1 | In-band interrupt on data line 1, active low |

## Verification
Commands are tried at each function's exact limit and one byte past it. They also use size 0, the unused function number and a zero block count, which separates a per-function limit from a single shared limit and an inclusive bound from an exclusive one. Multi-block transfers with gaps between blocks, stray blk_done pulses while idle and new commands during a transfer show whether the count-down and the idle/active gating are right. Clock-stopped cycles that carry blk_done and cmd_valid show whether state is truly frozen. The interrupt inputs are swept over enable masks, the master bit, bus width and busy, which tells the gated in-band path apart from the free-running out-of-band one.

// File: rtl/sdio_xfer_pkg.sv
// Shared parameters and helpers for the SDIO transfer controller.
// Assumes three card functions numbered 0..2; code 3 is unused.
package sdio_xfer_pkg;
    localparam int NUM_FN  = 3;
    localparam int FN_W    = 2;
    localparam int SIZE_W  = 10;
    localparam int CNT_W   = 9;

    // Largest block size / byte count allowed for a function; 0 = no such function
    function automatic int unsigned fn_max_size(input int unsigned fn);
        case (fn)
            0:       return 32;
            1:       return 64;
            2:       return 512;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/sdio_fn_limit.sv
// Combinational legality check for a decoded command.
// Assumes fn numbers outside 0..NFN-1 are illegal; size 0 and a block-mode
// count of 0 are illegal as well.
module sdio_fn_limit #(
    parameter int NFN = sdio_xfer_pkg::NUM_FN,
    parameter int FW  = sdio_xfer_pkg::FN_W,
    parameter int SW  = sdio_xfer_pkg::SIZE_W,
    parameter int CW  = sdio_xfer_pkg::CNT_W
) (
    input  logic [FW-1:0] fn,
    input  logic [SW-1:0] size,
    input  logic          block_mode,
    input  logic [CW-1:0] count,
    output logic          legal
);
    logic [NFN-1:0] fits;

    // One comparator per function against its own ceiling
    for (genvar g = 0; g < NFN; g++) begin : g_fn
        localparam logic [SW:0] LIMIT = (SW+1)'(sdio_xfer_pkg::fn_max_size(g));
        assign fits[g] = (fn == FW'(g)) && ({1'b0, size} <= LIMIT);
    end

    // Combine size, function and count legality
    always_comb begin
        legal = (|fits) && (size != '0) && (!block_mode || (count != '0));
    end
endmodule

// File: rtl/sdio_blk_seq.sv
// Transfer register set and block count-down.
// Assumes start and reject are mutually exclusive and only raised while idle.
// All state holds while en is low; reset wins regardless of en.
module sdio_blk_seq #(
    parameter int FW = sdio_xfer_pkg::FN_W,
    parameter int SW = sdio_xfer_pkg::SIZE_W,
    parameter int CW = sdio_xfer_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic          reject,
    input  logic [FW-1:0] start_fn,
    input  logic          start_write,
    input  logic [SW-1:0] start_size,
    input  logic [CW-1:0] start_blocks,
    input  logic          blk_done,
    output logic          active,
    output logic [FW-1:0] fn_q,
    output logic          write_q,
    output logic [SW-1:0] size_q,
    output logic [CW-1:0] left_q,
    output logic          done_q,
    output logic          err_q
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // Sequencer state: load on start, count down on blk_done, flag results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            fn_q    <= '0;
            write_q <= 1'b0;
            size_q  <= '0;
            left_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else if (en) begin
            done_q <= 1'b0;
            err_q  <= reject;
            if (start) begin
                active  <= 1'b1;
                fn_q    <= start_fn;
                write_q <= start_write;
                size_q  <= start_size;
                left_q  <= start_blocks;
            end else if (active && blk_done) begin
                left_q <= left_q - ONE;
                if (left_q == ONE) begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sdio_card_irq.sv
// Card interrupt generation in two forms.
// Out-of-band: ungated, combinational, valid with the clock stopped.
// In-band: data line 1 pulled low only in 4-bit mode while lines are idle.
module sdio_card_irq #(
    parameter int NFN = sdio_xfer_pkg::NUM_FN
) (
    input  logic [NFN-1:0] req,
    input  logic [NFN-1:0] en,
    input  logic           master_en,
    input  logic           wide_bus,
    input  logic           busy,
    output logic           oob,
    output logic           dat1_n
);
    logic pending;

    // Merge enabled requests and derive both interrupt forms
    always_comb begin
        pending = master_en && (|(req & en));
        oob     = pending;
        dat1_n  = !(pending && wide_bus && !busy);
    end
endmodule

// File: rtl/sdio_xfer_ctrl.sv
// SDIO multi-function transfer controller (top).
// Checks each decoded command against its function's size ceiling, runs the
// block count-down and raises the card interrupt. Assumes cmd_valid and
// blk_done are single-cycle strobes qualified by clk_en.
module sdio_xfer_ctrl #(
    parameter int NFN = sdio_xfer_pkg::NUM_FN,
    parameter int FW  = sdio_xfer_pkg::FN_W,
    parameter int SW  = sdio_xfer_pkg::SIZE_W,
    parameter int CW  = sdio_xfer_pkg::CNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clk_en,
    input  logic           cmd_valid,
    input  logic [FW-1:0]  cmd_fn,
    input  logic           cmd_write,
    input  logic           cmd_block,
    input  logic [SW-1:0]  cmd_size,
    input  logic [CW-1:0]  cmd_count,
    input  logic           blk_done,
    input  logic           dat_busy,
    input  logic           bus_4bit,
    input  logic [NFN-1:0] irq_req,
    input  logic [NFN-1:0] irq_en,
    input  logic           irq_master_en,
    output logic           xfer_active,
    output logic [FW-1:0]  xfer_fn,
    output logic           xfer_write,
    output logic [SW-1:0]  xfer_size,
    output logic [CW-1:0]  blocks_left,
    output logic           xfer_done,
    output logic           err_range,
    output logic           oob_irq,
    output logic           dat1_irq_n
);
    logic          legal;
    logic          take;
    logic          start;
    logic          reject;
    logic [CW-1:0] n_blocks;

    sdio_fn_limit #(.NFN(NFN), .FW(FW), .SW(SW), .CW(CW)) u_limit (
        .fn         (cmd_fn),
        .size       (cmd_size),
        .block_mode (cmd_block),
        .count      (cmd_count),
        .legal      (legal)
    );

    // Accept or refuse a command only while idle
    always_comb begin
        take     = cmd_valid && !xfer_active;
        start    = take && legal;
        reject   = take && !legal;
        n_blocks = cmd_block ? cmd_count : CW'(1);
    end

    sdio_blk_seq #(.FW(FW), .SW(SW), .CW(CW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (clk_en),
        .start        (start),
        .reject       (reject),
        .start_fn     (cmd_fn),
        .start_write  (cmd_write),
        .start_size   (cmd_size),
        .start_blocks (n_blocks),
        .blk_done     (blk_done),
        .active       (xfer_active),
        .fn_q         (xfer_fn),
        .write_q      (xfer_write),
        .size_q       (xfer_size),
        .left_q       (blocks_left),
        .done_q       (xfer_done),
        .err_q        (err_range)
    );

    sdio_card_irq #(.NFN(NFN)) u_irq (
        .req       (irq_req),
        .en        (irq_en),
        .master_en (irq_master_en),
        .wide_bus  (bus_4bit),
        .busy      (dat_busy),
        .oob       (oob_irq),
        .dat1_n    (dat1_irq_n)
    );
endmodule

// File: rtl/sdio_xfer_ctrl_chk.sv
// Property checker for sdio_xfer_ctrl, bound to every instance of the top.
module sdio_xfer_ctrl_chk #(
    parameter int NFN = 3,
    parameter int FW  = 2,
    parameter int SW  = 10,
    parameter int CW  = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clk_en,
    input logic           dat_busy,
    input logic           bus_4bit,
    input logic           irq_master_en,
    input logic           xfer_active,
    input logic [FW-1:0]  xfer_fn,
    input logic [SW-1:0]  xfer_size,
    input logic [CW-1:0]  blocks_left,
    input logic           xfer_done,
    input logic           err_range,
    input logic           oob_irq,
    input logic           dat1_irq_n
);
    // R3
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_range |-> !xfer_active);

    // R2
    size_within_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |-> ({22'd0, xfer_size} <= sdio_xfer_pkg::fn_max_size(32'(xfer_fn))));

    // R5
    done_ends_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!xfer_active && blocks_left == '0));

    // R5
    no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && $past(xfer_active)) |-> (blocks_left <= $past(blocks_left)));

    // R7
    frozen_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!clk_en) && $past(rst_n)) |-> ($stable(blocks_left) && $stable(xfer_active)));

    // R8
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_master_en |-> !oob_irq);

    // R9
    inband_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_busy || !bus_4bit) |-> dat1_irq_n);

    // R9
    inband_implies_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dat1_irq_n |-> oob_irq);
endmodule

bind sdio_xfer_ctrl sdio_xfer_ctrl_chk #(.NFN(NFN), .FW(FW), .SW(SW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clk_en        (clk_en),
    .dat_busy      (dat_busy),
    .bus_4bit      (bus_4bit),
    .irq_master_en (irq_master_en),
    .xfer_active   (xfer_active),
    .xfer_fn       (xfer_fn),
    .xfer_size     (xfer_size),
    .blocks_left   (blocks_left),
    .xfer_done     (xfer_done),
    .err_range     (err_range),
    .oob_irq       (oob_irq),
    .dat1_irq_n    (dat1_irq_n)
);

// File: tb/sdio_xfer_ctrl_test.sv
// Bench: behavioural reference model compared on every falling edge.
module sdio_xfer_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_fn = '0;
    logic       cmd_write = 1'b0;
    logic       cmd_block = 1'b0;
    logic [9:0] cmd_size = '0;
    logic [8:0] cmd_count = '0;
    logic       blk_done = 1'b0;
    logic       dat_busy = 1'b0;
    logic       bus_4bit = 1'b0;
    logic [2:0] irq_req = '0;
    logic [2:0] irq_en = '0;
    logic       irq_master_en = 1'b0;
    logic       xfer_active, xfer_write, xfer_done, err_range, oob_irq, dat1_irq_n;
    logic [1:0] xfer_fn;
    logic [9:0] xfer_size;
    logic [8:0] blocks_left;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference model state
    int m_active = 0, m_fn = 0, m_wr = 0, m_size = 0, m_left = 0, m_done = 0, m_err = 0;

    always #2 clk = ~clk;

    sdio_xfer_ctrl uut (.*);

    // Reference model of the registered behaviour
    always @(posedge clk) begin
        int lim, cnt;
        if (!rst_n) begin
            m_active = 0; m_fn = 0; m_wr = 0; m_size = 0; m_left = 0; m_done = 0; m_err = 0;
        end else if (clk_en) begin
            m_done = 0;
            m_err  = 0;
            if (m_active != 0) begin
                if (blk_done) begin
                    m_left = m_left - 1;
                    if (m_left == 0) begin m_active = 0; m_done = 1; end
                end
            end else if (cmd_valid) begin
                lim = (cmd_fn == 0) ? 32 : (cmd_fn == 1) ? 64 : (cmd_fn == 2) ? 512 : 0;
                cnt = cmd_block ? int'(cmd_count) : 1;
                if (cmd_size == 0 || int'(cmd_size) > lim || cnt == 0) m_err = 1;
                else begin
                    m_active = 1; m_fn = int'(cmd_fn); m_wr = int'(cmd_write);
                    m_size = int'(cmd_size); m_left = cnt;
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output on the falling edge
    always @(negedge clk) begin
        int pend;
        if (!finished) begin
            pend = (irq_master_en && ((irq_req & irq_en) != 0)) ? 1 : 0;
            check("R2/R6/R7", "xfer_active", int'(xfer_active), m_active);
            check("R2", "xfer_fn", int'(xfer_fn), m_fn);
            check("R2", "xfer_write", int'(xfer_write), m_wr);
            check("R2", "xfer_size", int'(xfer_size), m_size);
            check("R4/R5", "blocks_left", int'(blocks_left), m_left);
            check("R5", "xfer_done", int'(xfer_done), m_done);
            check("R3", "err_range", int'(err_range), m_err);
            check("R8", "oob_irq", int'(oob_irq), pend);
            check("R9", "dat1_irq_n", int'(dat1_irq_n),
                  (pend != 0 && bus_4bit && !dat_busy) ? 0 : 1);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic issue(input int fn, input int wr, input int blk, input int size, input int cnt);
        cmd_valid = 1'b1; cmd_fn = 2'(fn); cmd_write = wr[0]; cmd_block = blk[0];
        cmd_size = 10'(size); cmd_count = 9'(cnt);
        tick(1);
        cmd_valid = 1'b0;
        tick(1);
    endtask

    task automatic block(input int gap);
        blk_done = 1'b1;
        tick(1);
        blk_done = 1'b0;
        tick(gap);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;               // R1 reset state compared in the cycles above
        tick(1);
        // R2 R4 R5: function 0 at its limit, byte mode
        issue(0, 1, 0, 32, 0);
        block(1);
        // R3: one past function 0 limit
        issue(0, 0, 0, 33, 0);
        // R2 R4 R5 R6 R7: function 1 at limit, three blocks, with gaps and stalls
        issue(1, 0, 1, 64, 3);
        cmd_valid = 1'b1; cmd_fn = 2'd2; cmd_size = 10'd8; tick(1); cmd_valid = 1'b0; // R6
        block(2);
        clk_en = 1'b0; blk_done = 1'b1; tick(3); blk_done = 1'b0; clk_en = 1'b1;      // R7
        block(0);
        block(2);
        // R3: limits and illegal encodings
        issue(1, 0, 1, 65, 1);
        issue(2, 1, 0, 513, 0);
        issue(3, 0, 0, 8, 0);
        issue(2, 0, 0, 0, 0);
        issue(2, 0, 1, 16, 0);
        // R6: stray blk_done while idle
        block(1);
        // R2 R4: function 2 at limit, two blocks back to back
        issue(2, 1, 1, 512, 2);
        block(0);
        block(1);
        // R7: clock stopped with a command present
        clk_en = 1'b0; issue(0, 0, 0, 4, 0); clk_en = 1'b1; tick(1);
        // R7: reset while clock is stopped mid-transfer
        issue(1, 1, 1, 10, 5);
        clk_en = 1'b0; rst_n = 1'b0; tick(1); rst_n = 1'b1; clk_en = 1'b1; tick(1);
        // R8 R9: interrupt sweep
        for (int k = 0; k < 64; k++) begin
            irq_req = 3'(k); irq_en = 3'(k >> 3); irq_master_en = 1'b1;
            bus_4bit = k[0]; dat_busy = k[1]; clk_en = !k[2];
            tick(1);
        end
        clk_en = 1'b1;
        irq_req = 3'b100; irq_en = 3'b100; bus_4bit = 1'b1; dat_busy = 1'b0;
        irq_master_en = 1'b0; tick(1);   // R8 master off
        irq_master_en = 1'b1; tick(1);
        dat_busy = 1'b1; tick(1);       // R9 busy lines
        bus_4bit = 1'b0; dat_busy = 1'b0; tick(1); // R9 1-bit bus
        tick(2);
        finish_run();
    end
endmodule